// File: doc/BRIEF.md
# Debug Transaction Decoder

This block sits behind the frame receiver of a single-wire debug link. It accepts one frame at a time: a payload byte, the start-bit direction and the acknowledge result. From these frames it follows the transaction layout. A transaction begins with a short command code. For the two memory commands, the command is followed by a byte count, then a three-byte address sent most significant byte first, then that many data bytes. Decoded commands, the byte count and the assembled address appear as one-cycle event pulses. Data bytes leave on a valid/ready stream, tagged with their direction.

The decoder also tells the receiver how long the next payload is. A level output asks for a short command payload while the decoder waits for a command, and for a full byte payload at every other step. A synchronization pulse from the line layer returns the decoder to the command step at once.

Both frame interfaces follow valid/ready rules. A frame is taken on a clock edge where `frm_valid` and `frm_ready` are both high. `frm_ready` drops only while a data byte sits in the output register and `dat_ready` is low. A held output byte keeps its value and direction until the edge where `dat_ready` is seen high. Event pulses and the mode level cannot be stalled.

Top module: `dbg_txn_decoder`

## Requirements
- R1: After reset, `mode_short` is 1, `frm_ready` is 1, and `dat_valid`, `cmd_evt`, `cnt_evt` and `addr_evt` are all 0.
- R2: In the command step, code 0 in the low three bits of `frm_data` gives a `cmd_evt` pulse with `cmd_kind` 0 (system reset), and the decoder stays in the command step. The upper data bits are ignored.
- R3: Code 1 gives `cmd_kind` 1 (read) and code 2 gives `cmd_kind` 2 (write). Both move the decoder to the byte-count step, so `mode_short` becomes 0.
- R4: Codes 3 to 7 give `cmd_kind` 3 (unknown), and the decoder stays in the command step.
- R5: The frame after a memory command is the byte count. It is reported as a `cnt_evt` pulse with the value on `cnt_val`, and the decoder moves to the address step. At most one of the three event pulses is high in any cycle.
- R6: The next three frames form the address, first byte most significant. A single `addr_evt` pulse with the 24-bit value comes one cycle after the third address byte is taken.
- R7: In the data step, each byte is presented on the data stream with `dat_dir` equal to its frame's `frm_dir` (0 = write, 1 = read). After the counted number of bytes, the decoder returns to the command step. A count of 0 behaves like a count of 1.
- R8: `mode_short` is 1 exactly while the decoder is in the command step.
- R9: A `sync_det` pulse puts the decoder back in the command step by the following cycle. A frame taken on the same edge is discarded.
- R10: A taken frame with `frm_ack` 0 changes no state and produces no event or data byte.
- R11: While `dat_valid` is 1 and `dat_ready` is 0, `frm_ready` is 0, and `dat_byte` and `dat_dir` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_det | input | 1 | Synchronization frame seen on the line |
| frm_valid | input | 1 | Frame available |
| frm_ready | output | 1 | Decoder can take a frame |
| frm_data | input | 8 | Frame payload (command code in bits 2:0) |
| frm_dir | input | 1 | Start-bit value: 0 from host, 1 from target |
| frm_ack | input | 1 | Frame was acknowledged |
| mode_short | output | 1 | Request short command payloads |
| cmd_evt | output | 1 | Command decoded (one-cycle pulse) |
| cmd_kind | output | 2 | 0 reset, 1 read, 2 write, 3 unknown |
| cnt_evt | output | 1 | Byte count received (pulse) |
| cnt_val | output | 8 | Byte count value |
| addr_evt | output | 1 | Full address assembled (pulse) |
| addr_val | output | 24 | Assembled address |
| dat_valid | output | 1 | Data byte available |
| dat_ready | input | 1 | Consumer takes the data byte |
| dat_byte | output | 8 | Data byte |
| dat_dir | output | 1 | Data byte direction |

## Verification
Every result is registered once. The event pulses, the data byte and the updated `mode_short` all appear in the cycle after the edge that takes the frame, or after the edge that sees `sync_det`. The bench drives inputs on falling edges and checks every output at the next falling edge after the accepting rising edge, so each pulse is sampled in its only valid cycle. During back-pressure the held byte is checked on each stalled cycle. The byte taken after the stall is checked one cycle after `dat_ready` returns.

// File: rtl/dbg_txn_pkg.sv
package dbg_txn_pkg;

  typedef enum logic [1:0] {
    ST_CMD   = 2'd0,
    ST_COUNT = 2'd1,
    ST_ADDR  = 2'd2,
    ST_DATA  = 2'd3
  } txn_state_e;

  typedef enum logic [1:0] {
    KIND_SYSRST  = 2'd0,
    KIND_READ    = 2'd1,
    KIND_WRITE   = 2'd2,
    KIND_UNKNOWN = 2'd3
  } cmd_kind_e;

  function automatic cmd_kind_e classify(input logic [2:0] code);
    case (code)
      3'd0:    classify = KIND_SYSRST;
      3'd1:    classify = KIND_READ;
      3'd2:    classify = KIND_WRITE;
      default: classify = KIND_UNKNOWN;
    endcase
  endfunction

endpackage

// File: rtl/dbg_txn_fsm.sv
module dbg_txn_fsm
  import dbg_txn_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CMD_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              sync,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              addr_last,
  input  logic              data_last,
  output txn_state_e        state,
  output logic              cmd_evt,
  output logic [1:0]        cmd_kind,
  output logic              cnt_evt,
  output logic [DATA_W-1:0] cnt_val
);

  txn_state_e state_q, state_d;
  cmd_kind_e  kind_now;

  // Only the low command bits are decoded; zero-extend to the classifier width.
  always_comb begin
    logic [2:0] code;
    code = '0;
    code[CMD_W-1:0] = byte_in[CMD_W-1:0];
    kind_now = classify(code);
  end

  always_comb begin
    state_d = state_q;
    if (take) begin
      case (state_q)
        ST_CMD:   if (kind_now == KIND_READ || kind_now == KIND_WRITE) state_d = ST_COUNT;
        ST_COUNT: state_d = ST_ADDR;
        ST_ADDR:  if (addr_last) state_d = ST_DATA;
        ST_DATA:  if (data_last) state_d = ST_CMD;
        default:  state_d = ST_CMD;
      endcase
    end
    if (sync) state_d = ST_CMD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_CMD;
      cmd_evt  <= 1'b0;
      cmd_kind <= '0;
      cnt_evt  <= 1'b0;
      cnt_val  <= '0;
    end else begin
      state_q <= state_d;
      cmd_evt <= take && (state_q == ST_CMD);
      cnt_evt <= take && (state_q == ST_COUNT);
      if (take && state_q == ST_CMD)   cmd_kind <= kind_now;
      if (take && state_q == ST_COUNT) cnt_val  <= byte_in;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/dbg_txn_addr.sv
module dbg_txn_addr #(
  parameter int DATA_W     = 8,
  parameter int ADDR_BYTES = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         capture,
  input  logic                         sync,
  input  logic [DATA_W-1:0]            byte_in,
  output logic                         last,
  output logic                         addr_evt,
  output logic [ADDR_BYTES*DATA_W-1:0] addr
);

  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ADDR_BYTES - 1);

  logic [IDX_W-1:0] idx_q;

  assign last = (idx_q == IDX_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      addr_evt <= 1'b0;
    end else begin
      addr_evt <= capture && last;
      if (sync)         idx_q <= '0;
      else if (capture) idx_q <= last ? '0 : idx_q + 1'b1;
    end
  end

  // One register lane per address byte; the first byte received lands in
  // the most significant lane.
  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_lane
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(ADDR_BYTES - 1 - b);
    logic [DATA_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       lane_q <= '0;
      else if (capture && idx_q == SLOT) lane_q <= byte_in;
    end
    assign addr[b*DATA_W +: DATA_W] = lane_q;
  end

endmodule

// File: rtl/dbg_txn_count.sv
module dbg_txn_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  // A zero count is treated like one so the data step always ends.
  assign last = (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load)             cnt_q <= load_val;
    else if (step && !last)    cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/dbg_txn_dout.sv
module dbg_txn_dout #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              dir_in,
  input  logic              out_ready,
  output logic              space,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_dir
);

  assign space = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_dir   <= 1'b0;
    end else begin
      if (load) begin
        out_valid <= 1'b1;
        out_data  <= byte_in;
        out_dir   <= dir_in;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dbg_txn_decoder.sv
module dbg_txn_decoder
  import dbg_txn_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CMD_W      = 3,
  parameter int ADDR_BYTES = 3,
  localparam int ADDR_W    = DATA_W * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_det,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              frm_dir,
  input  logic              frm_ack,
  output logic              mode_short,
  output logic              cmd_evt,
  output logic [1:0]        cmd_kind,
  output logic              cnt_evt,
  output logic [DATA_W-1:0] cnt_val,
  output logic              addr_evt,
  output logic [ADDR_W-1:0] addr_val,
  output logic              dat_valid,
  input  logic              dat_ready,
  output logic [DATA_W-1:0] dat_byte,
  output logic              dat_dir
);

  txn_state_e state;
  logic       take;
  logic       addr_last;
  logic       data_last;
  logic       space;

  assign frm_ready  = space;
  assign take       = frm_valid && frm_ready && frm_ack && !sync_det;
  assign mode_short = (state == ST_CMD);

  dbg_txn_fsm #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .sync     (sync_det),
    .byte_in  (frm_data),
    .addr_last(addr_last),
    .data_last(data_last),
    .state    (state),
    .cmd_evt  (cmd_evt),
    .cmd_kind (cmd_kind),
    .cnt_evt  (cnt_evt),
    .cnt_val  (cnt_val)
  );

  dbg_txn_addr #(.DATA_W(DATA_W), .ADDR_BYTES(ADDR_BYTES)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (take && state == ST_ADDR),
    .sync    (sync_det),
    .byte_in (frm_data),
    .last    (addr_last),
    .addr_evt(addr_evt),
    .addr    (addr_val)
  );

  dbg_txn_count #(.CNT_W(DATA_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (take && state == ST_COUNT),
    .load_val(frm_data),
    .step    (take && state == ST_DATA),
    .last    (data_last)
  );

  dbg_txn_dout #(.DATA_W(DATA_W)) u_dout (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take && state == ST_DATA),
    .byte_in  (frm_data),
    .dir_in   (frm_dir),
    .out_ready(dat_ready),
    .space    (space),
    .out_valid(dat_valid),
    .out_data (dat_byte),
    .out_dir  (dat_dir)
  );

endmodule

// File: rtl/dbg_txn_decoder_chk.sv
module dbg_txn_decoder_chk #(
  parameter int DATA_W     = 8,
  parameter int CMD_W      = 3,
  parameter int ADDR_BYTES = 3,
  localparam int ADDR_W    = DATA_W * ADDR_BYTES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_det,
  input logic              frm_valid,
  input logic              frm_ready,
  input logic [DATA_W-1:0] frm_data,
  input logic              frm_dir,
  input logic              frm_ack,
  input logic              mode_short,
  input logic              cmd_evt,
  input logic [1:0]        cmd_kind,
  input logic              cnt_evt,
  input logic [DATA_W-1:0] cnt_val,
  input logic              addr_evt,
  input logic [ADDR_W-1:0] addr_val,
  input logic              dat_valid,
  input logic              dat_ready,
  input logic [DATA_W-1:0] dat_byte,
  input logic              dat_dir
);

  // R8: a command can only have been decoded while in the command step
  p_cmd_in_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_evt |-> $past(mode_short));

  // R3: a memory command has left the command step
  p_mem_leaves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_evt && (cmd_kind == 2'd1 || cmd_kind == 2'd2)) |-> !mode_short);

  // R4: an unknown command keeps the command step
  p_unknown_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_evt && cmd_kind == 2'd3) |-> mode_short);

  // R5: at most one event pulse per cycle
  p_one_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_evt, cnt_evt, addr_evt}));

  // R9: sync returns to the command step
  p_sync_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_det |=> mode_short);

  // R10: an unacknowledged frame changes nothing
  p_nack_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready && !frm_ack && !sync_det)
      |=> ($stable(mode_short) && !cmd_evt && !cnt_evt && !addr_evt));

  // R11: back-pressure blocks input and holds the output byte
  p_stall_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid && !dat_ready) |-> !frm_ready);

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid && !dat_ready) |=> (dat_valid && $stable(dat_byte) && $stable(dat_dir)));

endmodule

bind dbg_txn_decoder dbg_txn_decoder_chk #(
  .DATA_W(DATA_W), .CMD_W(CMD_W), .ADDR_BYTES(ADDR_BYTES)
) u_chk (.*);

// File: tb/test_dbg_txn_decoder.sv
module test_dbg_txn_decoder;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_det = 1'b0;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic [7:0]  frm_data = '0;
  logic        frm_dir = 1'b0;
  logic        frm_ack = 1'b0;
  logic        mode_short;
  logic        cmd_evt;
  logic [1:0]  cmd_kind;
  logic        cnt_evt;
  logic [7:0]  cnt_val;
  logic        addr_evt;
  logic [23:0] addr_val;
  logic        dat_valid;
  logic        dat_ready = 1'b1;
  logic [7:0]  dat_byte;
  logic        dat_dir;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_txn_decoder i_dbg_txn_decoder (.*);

  int n_chk = 0;
  int n_bad = 0;

  // reference model
  int          m_st = 0;    // 0 cmd, 1 count, 2 addr, 3 data
  int          m_idx = 0;
  int          m_cnt = 0;
  logic [23:0] m_addr = '0;
  bit          e_cmd, e_cnt, e_addr, e_dat;
  int          e_kind;
  logic [7:0]  e_cntv, e_datb;
  logic        e_datd;
  bit          e_nack;

  function automatic int kind_of(input logic [7:0] d);
    case (d[2:0])
      3'd0: return 0;
      3'd1: return 1;
      3'd2: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic string cmd_tag(input int k);
    if (k == 0) return "R2";
    if (k == 3) return "R4";
    return "R3";
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_step(input logic [7:0] d, input logic dir, input logic ack);
    e_cmd = 0; e_cnt = 0; e_addr = 0; e_dat = 0; e_nack = !ack;
    if (!ack) return;
    case (m_st)
      0: begin
        e_cmd = 1; e_kind = kind_of(d);
        if (e_kind == 1 || e_kind == 2) m_st = 1;
      end
      1: begin e_cnt = 1; e_cntv = d; m_cnt = d; m_st = 2; m_idx = 0; end
      2: begin
        m_addr = {m_addr[15:0], d};
        if (m_idx == 2) begin e_addr = 1; m_st = 3; m_idx = 0; end
        else m_idx++;
      end
      default: begin
        e_dat = 1; e_datb = d; e_datd = dir;
        if (m_cnt <= 1) m_st = 0; else m_cnt--;
      end
    endcase
  endtask

  task automatic verify();
    string t;
    t = e_nack ? "R10" : cmd_tag(e_kind);
    check(t, cmd_evt, e_cmd);
    if (e_cmd) check(t, cmd_kind, e_kind);
    check(e_nack ? "R10" : "R5", cnt_evt, e_cnt);
    if (e_cnt) check("R5", cnt_val, e_cntv);
    check(e_nack ? "R10" : "R6", addr_evt, e_addr);
    if (e_addr) check("R6", addr_val, m_addr);
    check(e_nack ? "R10" : "R7", dat_valid, e_dat);
    if (e_dat) begin
      check("R7", dat_byte, e_datb);
      check("R7", dat_dir, e_datd);
    end
    check(e_nack ? "R10" : "R8", mode_short, m_st == 0);
  endtask

  // starts and ends at a falling edge
  task automatic send(input logic [7:0] d, input logic dir, input logic ack);
    frm_valid = 1; frm_data = d; frm_dir = dir; frm_ack = ack;
    while (!frm_ready) @(negedge clk);
    model_step(d, dir, ack);
    @(posedge clk);
    @(negedge clk);
    frm_valid = 0;
    verify();
  endtask

  task automatic do_sync(input bit with_frame);
    sync_det = 1;
    if (with_frame) begin
      frm_valid = 1; frm_data = 8'h01; frm_dir = 0; frm_ack = 1;
    end
    @(posedge clk);
    @(negedge clk);
    sync_det = 0; frm_valid = 0;
    m_st = 0; m_idx = 0;
    check("R9", mode_short, 1);
    check("R9", cmd_evt | cnt_evt | addr_evt | dat_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", mode_short, 1);
    check("R1", frm_ready, 1);
    check("R1", dat_valid, 0);
    check("R1", cmd_evt | cnt_evt | addr_evt, 0);

    // R2, R4, R3 commands (upper bits ignored)
    send(8'hF8, 0, 1);
    send(8'h05, 0, 1);
    send(8'h0A, 0, 1);
    // R5 count, R6 address, R7 write data
    send(8'h02, 0, 1);
    send(8'h12, 0, 1);
    send(8'h34, 0, 1);
    send(8'h56, 0, 1);
    send(8'hAB, 0, 1);
    send(8'hCD, 0, 1);
    // R7 read with count 0: single byte then command step
    send(8'h01, 0, 1);
    send(8'h00, 0, 1);
    send(8'h00, 0, 1);
    send(8'h10, 0, 1);
    send(8'h20, 0, 1);
    send(8'h99, 1, 1);
    // R10 nack inside the address step
    send(8'h01, 0, 1);
    send(8'h03, 0, 1);
    send(8'h77, 0, 1);
    send(8'h66, 0, 0);
    send(8'h88, 0, 1);
    // R9 sync in the address step, then sync with a simultaneous frame
    do_sync(0);
    send(8'h02, 0, 1);
    do_sync(1);

    // R11 back-pressure
    send(8'h02, 0, 1);
    send(8'h02, 0, 1);
    send(8'h01, 0, 1);
    send(8'h02, 0, 1);
    send(8'h03, 0, 1);
    dat_ready = 0;
    send(8'hA5, 0, 1);
    check("R11", frm_ready, 0);
    frm_valid = 1; frm_data = 8'h3C; frm_dir = 1; frm_ack = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R11", frm_ready, 0);
      check("R11", dat_byte, 8'hA5);
      check("R11", dat_valid, 1);
      check("R11", mode_short, 0);
    end
    dat_ready = 1;
    model_step(8'h3C, 1, 1);
    @(posedge clk);
    @(negedge clk);
    frm_valid = 0;
    verify();

    // random traffic
    for (int n = 0; n < 600; n++) begin
      logic [7:0] d;
      logic ack;
      logic dir;
      if ($urandom % 50 == 0) begin
        do_sync($urandom % 2);
      end else begin
        ack = ($urandom % 10) != 0;
        dir = $urandom % 2;
        if (m_st == 0) begin
          d = $urandom;
          if ($urandom % 4 != 0) d[2:0] = 3'd1 + 3'($urandom % 2);
        end else if (m_st == 1) begin
          d = 8'($urandom % 6);
        end else begin
          d = $urandom;
        end
        send(d, dir, ack);
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule